// File: doc/BRIEF.md
# Split-Result Shift Unit

This block is the shift slice of a small clocked ALU. A three-bit operation code picks one of two operations on two four-bit operands. The first shifts operand A left by a run-time amount taken from operand B and fills the vacated positions with zeros. The second builds a fixed one-position right shift in which operand B supplies the bits that enter from the left. Every shift result is eight bits wide and appears as two four-bit halves. The register update happens on the rising clock edge.

The left shift uses a fixed number of two-way multiplexer stages, one for each bit of the shift amount that can still move a bit inside the eight-bit field. The hardware size therefore never depends on the operand value. When any higher bit of the shift amount is set, the result is forced to zero. A ready flag marks a recognised operation. An error flag is cleared by every update. The active-low reset is asynchronous.

Top module: `shl_split_unit`

## Requirements
- R1: With op_i = 3'b001, the registered 8-bit value {hi_o, lo_o} after the next rising edge equals the zero-extended a_i shifted left by the unsigned value of b_i, with zeros filling from the right. lo_o carries bits 3:0 and hi_o carries bits 7:4.
- R2: With op_i = 3'b001 and b_i = 0, lo_o equals a_i and hi_o is 0. With b_i = 4, hi_o equals a_i and lo_o is 0.
- R3: With op_i = 3'b001 and b_i of 8 or more, lo_o and hi_o are both 0 after the edge.
- R4: With op_i = 3'b010, lo_o becomes {b_i[0], a_i[3:1]} and hi_o becomes {1'b0, b_i[3:1]} after the edge.
- R5: After an edge on which op_i was 3'b001 or 3'b010, rdy_o is 1 and err_o is 0.
- R6: After an edge on which op_i was any other code, lo_o is 0, rdy_o is 0, err_o is 0, and hi_o keeps its previous value.
- R7: While rst_ni is low, lo_o, hi_o, rdy_o and err_o are 0, and this takes effect at once without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (001 left shift, 010 right merge) |
| a_i | input | 4 | Operand A, the value that is shifted |
| b_i | input | 4 | Operand B, the shift amount or the incoming bits |
| lo_o | output | 4 | Registered result bits 3:0 |
| hi_o | output | 4 | Registered result bits 7:4 |
| rdy_o | output | 1 | Registered flag, set after a recognised operation |
| err_o | output | 1 | Registered error flag, cleared on every update |

## Verification
Some properties are checked by the assertions on every cycle. They cover the zero result for oversized shift amounts, the shift-by-zero case, the top bit of the right-merge result, the ready and error flags after recognised codes, and the cleared low half together with the held high half after unrecognised codes. The shifter also confirms that it never creates set bits. The exact bit pattern for every combination of operand and amount, the shift-by-four boundary, and the immediate effect of reset in the middle of a cycle can only be shown by the bench scenarios. Those scenarios sweep both operations over every operand pair and compare the outputs against a behavioural model.

// File: rtl/shl_split_pkg.sv
package shl_split_pkg;

    localparam int unsigned OPND_W = 4;
    localparam int unsigned OPC_W  = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_SHL   = 3'b001,
        OPC_MERGE = 3'b010
    } opc_e;

    function automatic logic opc_known(input logic [OPC_W-1:0] code);
        return (code == OPC_SHL) || (code == OPC_MERGE);
    endfunction

endpackage

// File: rtl/shl_split_barrel.sv
module shl_split_barrel #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0]   val_i,
    input  logic [W-1:0]   amt_i,
    output logic [2*W-1:0] res_o
);
    localparam int unsigned RW = 2 * W;
    localparam int unsigned SB = $clog2(RW);

    logic [RW-1:0] stg [SB+1];
    logic          over;

    assign stg[0] = {{W{1'b0}}, val_i};

    // one mux stage per amount bit, stage s moves by 2**s
    for (genvar s = 0; s < SB; s++) begin : g_stage
        assign stg[s+1] = amt_i[s] ? (stg[s] << (2**s)) : stg[s];
    end

    // amount bits at or above SB push every bit out of the field
    if (W > SB) begin : g_over
        assign over = |amt_i[W-1:SB];
    end else begin : g_no_over
        assign over = 1'b0;
    end

    assign res_o = over ? '0 : stg[SB];

    // R1
    always_comb begin
        no_new_ones_chk: assert ($countones(res_o) <= $countones(val_i));
    end

endmodule

// File: rtl/shl_split_merge.sv
module shl_split_merge #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_o
);
    assign lo_o = {b_i[0], a_i[W-1:1]};
    assign hi_o = {1'b0, b_i[W-1:1]};
endmodule

// File: rtl/shl_split_unit.sv
module shl_split_unit
    import shl_split_pkg::*;
#(
    parameter int unsigned W = OPND_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [OPC_W-1:0] op_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    output logic [W-1:0]     lo_o,
    output logic [W-1:0]     hi_o,
    output logic             rdy_o,
    output logic             err_o
);
    localparam int unsigned RW = 2 * W;

    typedef struct packed {
        logic [W-1:0] lo;
        logic [W-1:0] hi;
        logic         rdy;
        logic         err;
    } res_t;

    res_t          st_d, st_q;
    logic [RW-1:0] shl_res;
    logic [W-1:0]  mrg_lo, mrg_hi;

    shl_split_barrel #(.W(W)) barrel_i (
        .val_i (a_i),
        .amt_i (b_i),
        .res_o (shl_res)
    );

    shl_split_merge #(.W(W)) merge_i (
        .a_i  (a_i),
        .b_i  (b_i),
        .lo_o (mrg_lo),
        .hi_o (mrg_hi)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        unique case (op_i)
            OPC_SHL: begin
                st_d.lo  = shl_res[W-1:0];
                st_d.hi  = shl_res[RW-1:W];
                st_d.rdy = 1'b1;
            end
            OPC_MERGE: begin
                st_d.lo  = mrg_lo;
                st_d.hi  = mrg_hi;
                st_d.rdy = 1'b1;
            end
            default: begin
                st_d.lo  = '0;
                st_d.rdy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lo_o  = st_q.lo;
    assign hi_o  = st_q.hi;
    assign rdy_o = st_q.rdy;
    assign err_o = st_q.err;

    // R3
    big_amt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OPC_SHL && b_i >= W'(RW)) |=> (lo_o == '0 && hi_o == '0));

    // R2
    zero_amt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OPC_SHL && b_i == '0) |=> (lo_o == $past(a_i) && hi_o == '0));

    // R4
    merge_top_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OPC_MERGE) |=> (hi_o[W-1] == 1'b0 && lo_o[W-1] == $past(b_i[0])));

    // R5
    known_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        opc_known(op_i) |=> (rdy_o && !err_o));

    // R6
    unknown_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !opc_known(op_i) |=> (lo_o == '0 && !rdy_o && !err_o && $stable(hi_o)));

endmodule

// File: tb/shl_split_unit_tb_top.sv
`timescale 1ns/1ps
module shl_split_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op = 3'b000;
    logic [3:0] a = 4'd0, b = 4'd0;
    logic [3:0] lo, hi;
    logic       rdy, err;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // reference state
    int m_lo = 0, m_hi = 0, m_rdy = 0, m_err = 0;

    always #2 clk = ~clk;

    shl_split_unit dut_i (
        .clk_i (clk), .rst_ni (rst_n), .op_i (op), .a_i (a), .b_i (b),
        .lo_o (lo), .hi_o (hi), .rdy_o (rdy), .err_o (err)
    );

    task automatic compare(input string tag);
        n_chk++;
        if (int'(lo) != m_lo || int'(hi) != m_hi || int'(rdy) != m_rdy || int'(err) != m_err) begin
            n_bad++;
            $display("FAIL %s: got lo=%0d hi=%0d rdy=%0d err=%0d, expected lo=%0d hi=%0d rdy=%0d err=%0d",
                     tag, lo, hi, rdy, err, m_lo, m_hi, m_rdy, m_err);
        end
    endtask

    // drive at negedge, one rising edge, compare at the following negedge
    task automatic step(input logic [2:0] o, input int av, input int bv, input string tag);
        int full;
        op = o; a = 4'(av); b = 4'(bv);
        @(negedge clk);
        m_err = 0;
        if (o == 3'b001) begin
            full  = (av << bv) & 255;
            m_lo  = full % 16;
            m_hi  = full / 16;
            m_rdy = 1;
        end else if (o == 3'b010) begin
            m_lo  = (bv % 2) * 8 + av / 2;
            m_hi  = bv / 2;
            m_rdy = 1;
        end else begin
            m_lo  = 0;
            m_rdy = 0;
        end
        compare(tag);
    endtask

    initial begin
        #1;
        m_lo = 0; m_hi = 0; m_rdy = 0; m_err = 0;
        compare("R7 reset state");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R7 after release");

        // R1 exhaustive left shift
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                step(3'b001, x, y, (y >= 8) ? "R3 big amount" : "R1 shift left");
        // R2 boundaries
        step(3'b001, 13, 0, "R2 amount zero");
        step(3'b001, 13, 4, "R2 amount four");
        step(3'b001, 15, 8, "R3 amount eight");
        step(3'b001, 15, 15, "R3 amount fifteen");
        // R4 exhaustive merge
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                step(3'b010, x, y, "R4 right merge");
        // R6 other codes hold high half
        step(3'b001, 9, 3, "R5 known code flags");
        step(3'b000, 5, 5, "R6 code 000");
        step(3'b111, 1, 2, "R6 code 111");
        step(3'b011, 7, 1, "R6 code 011");
        step(3'b010, 6, 11, "R5 merge flags");
        step(3'b100, 0, 0, "R6 code 100");
        step(3'b101, 3, 3, "R6 code 101");
        step(3'b110, 3, 3, "R6 code 110");
        step(3'b001, 15, 2, "R5 flags again");

        // R7 asynchronous reset mid-cycle
        #1 rst_n = 1'b0;
        #0.5;
        m_lo = 0; m_hi = 0; m_rdy = 0; m_err = 0;
        compare("R7 async reset");
        @(negedge clk);
        compare("R7 held in reset");
        rst_n = 1'b1;
        step(3'b001, 6, 1, "R1 after reset");

        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule